// File: doc/BRIEF.md
# Paged ROM Bus Target for a 6502 Host

This block sits on the bus of a 6502-family host and answers reads in the host's 16 KB paged ROM window, 0x8000 to 0xBFFF. The host picks which image appears in that window by writing an index to its page-select register at 0xFE05. The block snoops that write and keeps its own copy of the index. A 16-bit mask input tells the block which slot indices it owns. Other devices on the same bus, such as a built-in language ROM, answer the indices it does not own, so the block stays off the bus for those.

A fast system clock drives all the logic. The host's phi0 clock and read/write line pass through a two-stage synchronizer before their edges are detected. On a read that hits an owned slot, the block sends the address `{slot, A13:A0}` to an external backing memory and latches the returned byte. It then enables its data-bus driver while phi0 is still high. After phi0 falls, the driver stays on for a set number of system-clock cycles to give the host its hold time, and then turns off.

On a write to the page-select register, the block samples the data bus a set number of cycles after phi0 rises, because the host's write data becomes valid late in the cycle. If phi0 falls before that many cycles have passed, it samples at the fall instead.

Top module: `sideways_rom_target`

## Requirements
- R1: After reset the data-bus enable `dataOe` is low and the slot index is 0, so the first paged read serves slot 0 when slot 0 is owned.
- R2: A read whose address is in the paged window and whose current slot is owned drives the byte stored at memory address `{slot, A13:A0}` on `dataOut`, with `dataOe` high. The byte and the enable are in place before phi0 falls.
- R3: The paged window is the addresses with A15=1 and A14=0. A read at 0x7FFF, 0xC000 or 0x0123 leaves `dataOe` low, and reads at 0x8000 and 0xBFFF are served.
- R4: A paged read in a slot whose `ownMask` bit is 0 leaves `dataOe` low. Setting that bit makes the same read be served.
- R5: A host write to 0xFE05 loads data bits 3:0 into the slot index, and data bits 7:4 are ignored. The new index applies from the next bus cycle.
- R6: The page-select write is sampled WR_DELAY system cycles after the synchronized phi0 rise. Data on the bus 110 ns after the rise is taken, and earlier values are not.
- R7: If phi0 falls before WR_DELAY cycles have passed, the page-select write is sampled at the detected fall.
- R8: After phi0 falls on a served read, `dataOe` stays high for at least HOLD_CYCLES system cycles and is low within HOLD_CYCLES+4 cycles of the fall.
- R9: Back-to-back paged reads are each served, with none skipped.
- R10: A write inside the window, a write to any address other than 0xFE05, and a read of 0xFE05 never raise `dataOe`, and none of them changes the slot index.
- R11: If phi0 rises again while the hold period is still running, the new cycle is decoded and served as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phi0 | input | 1 | Host bus clock, asynchronous to clk |
| rnw | input | 1 | Host read (1) / write (0) |
| addr | input | 16 | Host address bus |
| dataIn | input | 8 | Host data bus as seen by the receiver |
| ownMask | input | 16 | One bit per slot, 1 means this block serves it |
| memData | input | 8 | Backing memory read data, one clk after memAddr |
| memAddr | output | 18 | Backing memory address `{slot, A13:A0}` |
| dataOut | output | 8 | Byte to drive onto the host data bus |
| dataOe | output | 1 | Data-bus driver enable (high = drive) |

## Verification
Two functions can fall in the same system-clock cycle: the end of one cycle's hold period and the decode of the next phi0 rise. The bench provokes this by shortening the phi0 low phase below the hold time, so that the rise is detected while the hold counter is still running. The result is judged at the next phi0 fall, where the byte for the new address must be on the bus with the enable high. A second overlap comes from a short write cycle, where the phi0 fall reaches the page-select sampler before its delay count runs out. The bench corrupts the bus shortly after that fall, so only a sample taken at the fall gives the new slot, and a following read checks it.

// File: rtl/sideways_pkg.sv
package sideways_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic captureAddr;  // register memory address for a served read
    logic loadData;     // latch memory byte into the output register
    logic driveOn;      // enable the data-bus driver
    logic driveOff;     // release the data-bus driver
    logic sampleSlot;   // load the slot index from the data bus
  } strobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DRIVE,
    ST_HOLD,
    ST_WSAMPLE
  } busState_t;

endpackage

// File: rtl/sideways_sync.sv
module sideways_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/sideways_ctrl.sv
module sideways_ctrl
  import sideways_pkg::*;
#(
  parameter int HOLD_CYCLES = 8,
  parameter int WR_DELAY    = 26,
  parameter int MEM_LAT     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     phi0,
  input  logic     rnw,
  input  logic     readHit,
  input  logic     slotWriteHit,
  output logic     rnwSync,
  output strobes_t strobes
);

  localparam int MAX_A   = (HOLD_CYCLES > WR_DELAY) ? HOLD_CYCLES : WR_DELAY;
  localparam int CNT_MAX = (MAX_A > MEM_LAT) ? MAX_A : MEM_LAT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_DELAY - 1);
  localparam logic [CNT_W-1:0] LAT_END   = CNT_W'(MEM_LAT);
  localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(CNT_MAX);

  logic [1:0] syncOut;
  logic       phi0Sync;
  logic       phi0Prev;
  logic       phi0Rise;
  logic       phi0Fall;

  sideways_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({phi0, rnw}),
    .dout (syncOut)
  );

  assign phi0Sync = syncOut[1];
  assign rnwSync  = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phi0Prev <= 1'b0;
    else       phi0Prev <= phi0Sync;
  end

  assign phi0Rise = phi0Sync & ~phi0Prev;
  assign phi0Fall = ~phi0Sync & phi0Prev;

  busState_t       state, nextState;
  logic [CNT_W-1:0] cnt;

  // Decision taken on a detected rise, shared by idle and hold states
  busState_t riseState;
  logic      riseCapture;

  always_comb begin
    riseState   = ST_IDLE;
    riseCapture = 1'b0;
    if (readHit) begin
      riseState   = ST_FETCH;
      riseCapture = 1'b1;
    end else if (slotWriteHit) begin
      riseState = ST_WSAMPLE;
    end
  end

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (phi0Rise) begin
          nextState           = riseState;
          strobes.captureAddr = riseCapture;
        end
      end
      ST_FETCH: begin
        if (cnt == LAT_END) begin
          strobes.loadData = 1'b1;
          strobes.driveOn  = 1'b1;
          nextState        = ST_DRIVE;
        end
      end
      ST_DRIVE: begin
        if (phi0Fall) nextState = ST_HOLD;
      end
      ST_HOLD: begin
        if (phi0Rise) begin
          strobes.driveOff    = 1'b1;
          strobes.captureAddr = riseCapture;
          nextState           = riseState;
        end else if (cnt == HOLD_LAST) begin
          strobes.driveOff = 1'b1;
          nextState        = ST_IDLE;
        end
      end
      ST_WSAMPLE: begin
        if (phi0Fall || cnt == WR_LAST) begin
          strobes.sampleSlot = 1'b1;
          nextState          = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) cnt <= '0;
      else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sideways_dp.sv
module sideways_dp
  import sideways_pkg::*;
#(
  parameter int          SLOT_BITS   = 4,
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter logic [15:0] SELECT_ADDR = 16'hFE05
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobes_t                      strobes,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          rnwSync,
  input  logic [DATA_W-1:0]             dataIn,
  input  logic [(1<<SLOT_BITS)-1:0]     ownMask,
  input  logic [DATA_W-1:0]             memData,
  output logic                          readHit,
  output logic                          slotWriteHit,
  output logic [SLOT_BITS+ADDR_W-3:0]   memAddr,
  output logic [DATA_W-1:0]             dataOut,
  output logic                          dataOe
);

  localparam int SLOTS       = 1 << SLOT_BITS;
  localparam int OFFSET_BITS = ADDR_W - 2;

  logic [SLOT_BITS-1:0] slotReg;
  logic [SLOTS-1:0]     slotMatch;
  logic                 slotOwned;
  logic                 inWindow;
  logic                 unusedDataHi;

  assign unusedDataHi = ^dataIn[DATA_W-1:SLOT_BITS];

  // Window: top two address bits equal 2'b10
  assign inWindow = (addr[ADDR_W-1 -: 2] == 2'b10);

  for (genvar s = 0; s < SLOTS; s++) begin : gOwn
    assign slotMatch[s] = (slotReg == SLOT_BITS'(s)) & ownMask[s];
  end
  assign slotOwned = |slotMatch;

  assign readHit      = rnwSync & inWindow & slotOwned;
  assign slotWriteHit = ~rnwSync & (addr == SELECT_ADDR[ADDR_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotReg <= '0;
      memAddr <= '0;
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      if (strobes.sampleSlot)  slotReg <= dataIn[SLOT_BITS-1:0];
      if (strobes.captureAddr) memAddr <= {slotReg, addr[OFFSET_BITS-1:0]};
      if (strobes.loadData)    dataOut <= memData;
      if (strobes.driveOn)       dataOe <= 1'b1;
      else if (strobes.driveOff) dataOe <= 1'b0;
    end
  end

endmodule

// File: rtl/sideways_rom_target.sv
module sideways_rom_target
  import sideways_pkg::*;
#(
  parameter int SLOT_BITS   = 4,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int HOLD_CYCLES = 8,
  parameter int WR_DELAY    = 26,
  parameter int MEM_LAT     = 1,
  parameter int SYNC_STAGES = 2,
  localparam int SLOTS      = 1 << SLOT_BITS,
  localparam int MEM_AW     = SLOT_BITS + ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phi0,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [SLOTS-1:0]  ownMask,
  input  logic [DATA_W-1:0] memData,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  strobes_t strobes;
  logic     rnwSync;
  logic     readHit;
  logic     slotWriteHit;

  sideways_ctrl #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .WR_DELAY    (WR_DELAY),
    .MEM_LAT     (MEM_LAT),
    .SYNC_STAGES (SYNC_STAGES)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .phi0         (phi0),
    .rnw          (rnw),
    .readHit      (readHit),
    .slotWriteHit (slotWriteHit),
    .rnwSync      (rnwSync),
    .strobes      (strobes)
  );

  sideways_dp #(
    .SLOT_BITS (SLOT_BITS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .addr         (addr),
    .rnwSync      (rnwSync),
    .dataIn       (dataIn),
    .ownMask      (ownMask),
    .memData      (memData),
    .readHit      (readHit),
    .slotWriteHit (slotWriteHit),
    .memAddr      (memAddr),
    .dataOut      (dataOut),
    .dataOe       (dataOe)
  );

endmodule

// File: rtl/sideways_rom_target_chk.sv
module sideways_rom_target_chk #(
  parameter int SLOT_BITS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  localparam int SLOTS    = 1 << SLOT_BITS,
  localparam int MEM_AW   = SLOT_BITS + ADDR_W - 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              phi0,
  input logic              rnw,
  input logic [SLOTS-1:0]  ownMask,
  input logic [MEM_AW-1:0] memAddr,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe
);

  // R4: drive only starts for a slot that is owned
  assert_drive_owned_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> ownMask[memAddr[MEM_AW-1 -: SLOT_BITS]]);

  // R2: drive begins while phi0 is still high
  assert_drive_in_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> phi0);

  // R2: byte on the bus does not change while it is driven
  assert_data_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe)) |-> $stable(dataOut));

  // R10: a host write cycle never turns the driver on
  assert_no_drive_on_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> rnw);

endmodule

bind sideways_rom_target sideways_rom_target_chk #(
  .SLOT_BITS (SLOT_BITS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .phi0    (phi0),
  .rnw     (rnw),
  .ownMask (ownMask),
  .memAddr (memAddr),
  .dataOut (dataOut),
  .dataOe  (dataOe)
);

// File: tb/sideways_rom_target_test.sv
module sideways_rom_target_test;

  localparam int HOLD = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phi0 = 1'b0;
  logic        rnw = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  dataIn = 8'h00;
  logic [15:0] ownMask = 16'h0000;
  logic [7:0]  memData = 8'h00;
  logic [17:0] memAddr;
  logic [7:0]  dataOut;
  logic        dataOe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sideways_rom_target uut (
    .clk     (clk),
    .rstN    (rstN),
    .phi0    (phi0),
    .rnw     (rnw),
    .addr    (addr),
    .dataIn  (dataIn),
    .ownMask (ownMask),
    .memData (memData),
    .memAddr (memAddr),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

  function automatic logic [7:0] memFn(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {a[17:14], a[17:14]} ^ 8'h3C;
  endfunction

  // Backing memory: one cycle read latency
  always @(posedge clk) memData <= memFn(memAddr);

  typedef struct {
    bit         expOe;
    logic [7:0] expData;
    bit         relChk;
    string      tag;
  } item_t;

  item_t expQ[$];
  logic [3:0] slotModel = 4'd0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One host bus cycle: lead-in low, high phase, then 4 low cycles
  task automatic busCycle(input logic [15:0] a, input bit rd, input logic [7:0] wd,
                          input int hiC, input int loC, input bit relChk, input string tag);
    item_t it;
    int validAt;
    validAt = (hiC < 30) ? 5 : 22;
    addr = a;
    rnw  = rd;
    dataIn = ~wd;
    it.expOe   = rd && (a[15:14] == 2'b10) && ownMask[slotModel];
    it.expData = memFn({slotModel, a[13:0]});
    it.relChk  = relChk;
    it.tag     = tag;
    expQ.push_back(it);
    repeat (loC) @(negedge clk);
    phi0 = 1'b1;
    for (int i = 0; i < hiC; i++) begin
      if (!rd && i == validAt) dataIn = wd;
      @(negedge clk);
    end
    phi0 = 1'b0;
    repeat (4) @(negedge clk);
    dataIn = ~wd;
    if (!rd && a == 16'hFE05) slotModel = wd[3:0];
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    busCycle(a, 1'b1, 8'h00, 50, 46, 1'b1, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    busCycle(a, 1'b0, d, 50, 46, 1'b0, tag);
  endtask

  // Monitor: compares bus state at each phi0 fall
  initial begin
    item_t it;
    forever begin
      @(negedge phi0);
      if (expQ.size() == 0) begin
        check(1'b0, "queue-empty", 0, 1);
      end else begin
        it = expQ.pop_front();
        check(dataOe == it.expOe && (!it.expOe || dataOut == it.expData),
              it.tag, {dataOe, dataOut}, {it.expOe, it.expData});
        if (it.expOe && it.relChk) begin
          repeat (HOLD) @(negedge clk);
          check(dataOe == 1'b1, "R8 hold", dataOe, 1);
          repeat (4) @(negedge clk);
          check(dataOe == 1'b0, "R8 release", dataOe, 0);
        end
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    ownMask = 16'h3001;  // slots 0, 12, 13
    repeat (5) @(negedge clk);
    check(dataOe == 1'b0, "R1 oe at reset", dataOe, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(dataOe == 1'b0, "R1 oe after reset", dataOe, 0);

    rd(16'h8000, "R1 slot0 read");
    rd(16'hBFFF, "R3 top of window");
    rd(16'h7FFF, "R3 below window");
    rd(16'hC000, "R3 above window");
    rd(16'h0123, "R3 low memory");

    wr(16'hFE05, 8'h0C, "R6 late write data");
    rd(16'h9234, "R5 slot12 read");

    wr(16'hFE05, 8'h05, "R5 select 5");
    rd(16'h8100, "R4 unowned slot");
    ownMask = 16'h3021;
    rd(16'h8100, "R4 owned after mask");

    busCycle(16'hFE05, 1'b0, 8'h0D, 20, 46, 1'b0, "R7 short write");
    rd(16'hA000, "R7 slot13 read");

    wr(16'h8000, 8'h00, "R10 window write");
    wr(16'hFE04, 8'h00, "R10 other write");
    rd(16'hFE05, "R10 select read");
    rd(16'h8001, "R10 slot kept");

    rd(16'h8010, "R9 burst 0");
    rd(16'h9FFF, "R9 burst 1");
    rd(16'hA5A5, "R9 burst 2");
    rd(16'hB3C4, "R9 burst 3");

    busCycle(16'h8ABC, 1'b1, 8'h00, 50, 46, 1'b0, "R11 first");
    busCycle(16'hB00F, 1'b1, 8'h00, 50, 2, 1'b1, "R11 rise in hold");

    wr(16'hFE05, 8'hF0, "R5 upper bits");
    rd(16'h8F0F, "R5 slot0 again");

    repeat (40) @(negedge clk);
    check(expQ.size() == 0, "queue drained", expQ.size(), 0);
    finishRun();
  end

endmodule